// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit ports, A and B, in both directions. Each direction has its own storage register with its own clock. The A-to-B register samples the A input on a rising edge of its clock. The B-to-A register samples the B input on a rising edge of its clock.

A per-direction select decides what the driven port shows: the live value of the opposite input, passed straight through with no clock, or the value held in that direction's register. An active-low enable and a direction input decide which port is driven, if either is. Each pad is modelled as a data output plus an enable, and the two enables are never both asserted. The registers keep capturing while both ports are isolated.

A build parameter makes both output paths inverting, for live data and for stored data alike. The select multiplexer carries a redundant consensus term, so a change of select while the live and stored values agree leaves the output steady.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `clk_ab_i`, the A-to-B register loads `a_i`.
- R2: On each rising edge of `clk_ba_i`, the B-to-A register loads `b_i`.
- R3: `sel_ab_i`=1 makes `b_o` show the A-to-B register. `sel_ab_i`=0 makes `b_o` follow `a_i` combinationally, with no clock edge needed. While stored data is selected, changes on `a_i` between clock edges leave `b_o` unchanged.
- R4: `sel_ba_i`=1 makes `a_o` show the B-to-A register. `sel_ba_i`=0 makes `a_o` follow `b_i` combinationally.
- R5: With `oe_ni`=0, `dir_i`=1 drives port B (`b_oe_o`=1, `a_oe_o`=0), and `dir_i`=0 drives port A (`a_oe_o`=1, `b_oe_o`=0).
- R6: With `oe_ni`=1, `a_oe_o` and `b_oe_o` are both 0.
- R7: Both registers capture on their clocks whatever the values of `oe_ni` and `dir_i`, including in isolation.
- R8: `a_oe_o` and `b_oe_o` are never 1 at the same time.
- R9: With `INVERT`=1, `a_o` and `b_o` are the bitwise complement of the selected live or stored data. With `INVERT`=0, they equal it.
- R10: `rst_ni`=0 clears both registers to zero at once, with no clock edge needed.
- R11: Toggling a select while its live and stored values are equal leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab_i | input | 1 | Capture clock of the A-to-B register |
| clk_ba_i | input | 1 | Capture clock of the B-to-A register |
| rst_ni | input | 1 | Asynchronous active-low clear of both registers |
| oe_ni | input | 1 | Active-low output enable |
| dir_i | input | 1 | 1: drive B, 0: drive A |
| sel_ab_i | input | 1 | Source for B: 1 stored, 0 live |
| sel_ba_i | input | 1 | Source for A: 1 stored, 0 live |
| a_i | input | WIDTH | Port A input value |
| b_i | input | WIDTH | Port B input value |
| a_o | output | WIDTH | Data presented on port A |
| a_oe_o | output | 1 | Port A drive enable |
| b_o | output | WIDTH | Data presented on port B |
| b_oe_o | output | 1 | Port B drive enable |

## Verification
The assertions check on every capture edge that the two drive enables never overlap, that they match the enable and direction inputs, and that each live path equals its input with the build polarity applied. They also check that a stored path shows the value captured at the previous edge of its own clock.

Some behaviours appear only between clock edges, so only the bench's scenarios can show them: the asynchronous clear, the stored output ignoring input changes with no clock, and a steady output while a select toggles. The bench also shows capture during isolation with a later readout, and the inverting build side by side with the true build.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drv_e;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/bxr_capture_reg.sv
module bxr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/bxr_hazard_free_mux.sv
module bxr_hazard_free_mux #(
  parameter int WIDTH = 8
) (
  input  bxr_pkg::src_e    sel_i,
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] stored_i,
  output logic [WIDTH-1:0] y_o
);
  logic s;
  assign s = (sel_i == bxr_pkg::SRC_STORED);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // consensus term holds the output when both inputs agree
    assign y_o[i] = (s & stored_i[i]) | (~s & live_i[i]) | (stored_i[i] & live_i[i]);
  end
endmodule

// File: rtl/bxr_port_ctrl.sv
module bxr_port_ctrl (
  input  logic oe_ni,
  input  logic dir_i,
  output logic a_oe_o,
  output logic b_oe_o
);
  import bxr_pkg::*;
  drv_e drv;

  always_comb begin
    if (oe_ni)      drv = DRV_NONE;
    else if (dir_i) drv = DRV_B;
    else            drv = DRV_A;
  end

  assign a_oe_o = (drv == DRV_A);
  assign b_oe_o = (drv == DRV_B);
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk_ab_i,
  input  logic             clk_ba_i,
  input  logic             rst_ni,
  input  logic             oe_ni,
  input  logic             dir_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o
);
  import bxr_pkg::*;

  logic [WIDTH-1:0] reg_ab, reg_ba;
  logic [WIDTH-1:0] mux_b, mux_a;

  bxr_capture_reg #(.WIDTH(WIDTH)) u_reg_ab (
    .clk_i(clk_ab_i), .rst_ni(rst_ni), .d_i(a_i), .q_o(reg_ab)
  );

  bxr_capture_reg #(.WIDTH(WIDTH)) u_reg_ba (
    .clk_i(clk_ba_i), .rst_ni(rst_ni), .d_i(b_i), .q_o(reg_ba)
  );

  bxr_hazard_free_mux #(.WIDTH(WIDTH)) u_mux_b (
    .sel_i(src_e'(sel_ab_i)), .live_i(a_i), .stored_i(reg_ab), .y_o(mux_b)
  );

  bxr_hazard_free_mux #(.WIDTH(WIDTH)) u_mux_a (
    .sel_i(src_e'(sel_ba_i)), .live_i(b_i), .stored_i(reg_ba), .y_o(mux_a)
  );

  bxr_port_ctrl u_ctrl (
    .oe_ni(oe_ni), .dir_i(dir_i), .a_oe_o(a_oe_o), .b_oe_o(b_oe_o)
  );

  if (INVERT) begin : g_inv
    assign a_o = ~mux_a;
    assign b_o = ~mux_b;
  end else begin : g_true
    assign a_o = mux_a;
    assign b_o = mux_b;
  end
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input logic             clk_ab_i,
  input logic             clk_ba_i,
  input logic             rst_ni,
  input logic             oe_ni,
  input logic             dir_i,
  input logic             sel_ab_i,
  input logic             sel_ba_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] a_o,
  input logic             a_oe_o,
  input logic [WIDTH-1:0] b_o,
  input logic             b_oe_o
);
  localparam logic [WIDTH-1:0] MASK = INVERT ? '1 : '0;

  // R8
  no_dual_drive_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o));

  // R6
  isolate_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    oe_ni |-> (!a_oe_o && !b_oe_o));

  // R5
  dir_drive_chk: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    !oe_ni |-> (b_oe_o == dir_i && a_oe_o == !dir_i));

  // R3
  live_b_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !sel_ab_i |-> (b_o == (a_i ^ MASK)));

  // R4
  live_a_chk: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    !sel_ba_i |-> (a_o == (b_i ^ MASK)));

  // R1
  stored_b_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    sel_ab_i |=> (!sel_ab_i || b_o == ($past(a_i) ^ MASK)));

  // R2
  stored_a_chk: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    sel_ba_i |=> (!sel_ba_i || a_o == ($past(b_i) ^ MASK)));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (.*);

// File: tb/bus_xcvr_reg_tb.sv
module bus_xcvr_reg_tb;
  localparam int W = 8;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic en_ab = 1'b0, en_ba = 1'b0;
  logic clk_ab, clk_ba;
  logic rst_n = 1'b0, oe_n = 1'b1, dir = 1'b0, sab = 1'b1, sba = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] a_o, b_o, a_o_inv, b_o_inv;
  logic a_oe, b_oe, a_oe_inv, b_oe_inv;

  always #2 clk = ~clk;
  assign clk_ab = clk & en_ab;
  assign clk_ba = clk & en_ba;

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b0)) u_dut (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n), .oe_ni(oe_n), .dir_i(dir),
    .sel_ab_i(sab), .sel_ba_i(sba), .a_i(a), .b_i(b),
    .a_o(a_o), .a_oe_o(a_oe), .b_o(b_o), .b_oe_o(b_oe));

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b1)) u_dut_inv (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n), .oe_ni(oe_n), .dir_i(dir),
    .sel_ab_i(sab), .sel_ba_i(sba), .a_i(a), .b_i(b),
    .a_o(a_o_inv), .a_oe_o(a_oe_inv), .b_o(b_o_inv), .b_oe_o(b_oe_inv));

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  // {oe_n, dir, sab, sba, en_ab, en_ba, exp_a_oe, exp_b_oe, a, b}
  localparam logic [23:0] VECS [NV] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3C, 8'hA5},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h77, 8'h11},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h55, 8'h22},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hF0, 8'h0F},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h12, 8'h34},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h99, 8'h88},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h00},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_b();
    return sab ? m_ab : a;
  endfunction

  function automatic logic [W-1:0] exp_a();
    return sba ? m_ba : b;
  endfunction

  task automatic check_outputs(input string req);
    chk({req, " b_o"}, b_o, exp_b());
    chk({req, " a_o"}, a_o, exp_a());
    chk("R9 b_o inverted", b_o_inv, ~exp_b());
    chk("R9 a_o inverted", a_o_inv, ~exp_a());
    chk("R8 enable overlap", W'(a_oe & b_oe), '0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state: both registers zero, isolated
    #5;
    chk("R10 reset b_o", b_o, '0);
    chk("R10 reset a_o", a_o, '0);
    chk("R10 reset inv b_o", b_o_inv, '1);
    chk("R6 reset a_oe", W'(a_oe), '0);
    chk("R6 reset b_oe", W'(b_oe), '0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VECS[i];
      @(negedge clk);
      {oe_n, dir, sab, sba, en_ab, en_ba} = v[23:18];
      a = v[15:8]; b = v[7:0];
      @(posedge clk);
      if (en_ab) m_ab = a;   // R1
      if (en_ba) m_ba = b;   // R2 / R7 when isolated
      #1;
      chk("R5/R6 a_oe", W'(a_oe), W'(v[17]));
      chk("R5/R6 b_oe", W'(b_oe), W'(v[16]));
      check_outputs("R1/R2/R3/R4/R7 vec");
      @(negedge clk); en_ab = 1'b0; en_ba = 1'b0;
    end

    // R3: live path follows a_i with no clock
    @(negedge clk); sab = 1'b0; a = 8'h5A; #1;
    chk("R3 live b_o", b_o, 8'h5A);
    a = 8'hC3; #1;
    chk("R3 live b_o no clock", b_o, 8'hC3);
    // R3: stored path ignores a_i with no clock
    sab = 1'b1; #1;
    chk("R3 stored b_o", b_o, m_ab);
    a = ~m_ab; #1;
    chk("R3 stored ignores a_i", b_o, m_ab);
    // R4: live path follows b_i with no clock
    sba = 1'b0; b = 8'h6E; #1;
    chk("R4 live a_o", a_o, 8'h6E);
    sba = 1'b1; #1;
    chk("R4 stored a_o", a_o, m_ba);

    // R11: select toggles with equal live and stored data
    a = m_ab; b = m_ba; #1;
    for (int k = 0; k < 4; k++) begin
      sab = ~sab; sba = ~sba; #1;
      chk("R11 b_o steady", b_o, m_ab);
      chk("R11 a_o steady", a_o, m_ba);
    end

    // R7: capture in isolation, then read out
    @(negedge clk); oe_n = 1'b1; a = 8'hE1; b = 8'h1E; en_ab = 1'b1; en_ba = 1'b1;
    sab = 1'b1; sba = 1'b1;
    @(posedge clk); m_ab = a; m_ba = b;
    @(negedge clk); en_ab = 1'b0; en_ba = 1'b0; oe_n = 1'b0; dir = 1'b1; a = 8'h00; b = 8'h00; #1;
    chk("R7 isolated capture b_o", b_o, 8'hE1);
    chk("R7 isolated capture a_o", a_o, 8'h1E);
    chk("R5 dir=1 b_oe", W'(b_oe), W'(1'b1));

    // R10: asynchronous clear between edges
    #0.5 rst_n = 1'b0; #0.5;
    m_ab = '0; m_ba = '0;
    chk("R10 async clear b_o", b_o, '0);
    chk("R10 async clear a_o", a_o, '0);
    chk("R10 async clear inv a_o", a_o_inv, '1);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule